// File: doc/BRIEF.md
# Hot-plug detect deglitch filter

This block turns a raw, asynchronous hot-plug detect line into a clean, stable level. It also produces one-cycle rise and fall events that an interrupt block can latch. First the input is brought into the clock domain by a two-flop synchroniser. After that, a change away from the accepted level must pass two qualification stages before it is committed:

- a fine glitch stage, which counts single cycles against a 4-bit threshold;
- a coarse stage, whose threshold is a 12-bit value in units of 1024 cycles.

Both thresholds come from a single 16-bit configuration word. When both are zero, the input is only synchronised.

The committed level can be read as bit 0 of a status word. The other status bits read as zero. When the level changes, exactly one event pulse is raised on the matching output, in the same cycle as the new level appears.

Top module: `hpd_deglitch`

## Requirements
- R1: While reset is held and after it is released, the status word is zero and neither event output is high, until a qualified change occurs.
- R2: The raw input passes through two synchroniser flops. With a zero configuration word, a change on the raw input is committed at the third rising clock edge after it.
- R3: A departure from the committed level that lasts N sampled cycles or fewer is discarded. N is the glitch field in configuration bits 15:12.
- R4: A departure lasting longer than K cycles is committed at the (3+K)-th rising edge after the raw change, where K is the larger of N and M×1024.
- R5: A departure lasting M×1024 cycles or fewer is discarded. M is the valid-width field in configuration bits 11:0.
- R6: Any return of the synchronised input to the committed level restarts both qualification counts from zero.
- R7: The rise output is high for exactly one cycle, in the cycle in which status bit 0 first reads 1.
- R8: The fall output is high for exactly one cycle, in the cycle in which status bit 0 first reads 0.
- R9: Status bit 0 carries the committed level, and all other status bits read 0.
- R10: The event outputs are raised only when the committed level actually changes, and never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpd_raw | input | 1 | Asynchronous hot-plug detect line |
| filt_cfg | input | 16 | Bits 15:12 glitch threshold N, bits 11:0 valid-width threshold M |
| hpd_stat | output | 8 | Bit 0 committed level, other bits zero |
| hpd_rise | output | 1 | One-cycle event on a committed rising change |
| hpd_fall | output | 1 | One-cycle event on a committed falling change |

## Verification
The bound checker watches the following on every cycle:

- each event lasts one cycle;
- each event agrees with the change of the status level;
- no level change happens without an event;
- rise and fall never coincide;
- the upper status bits stay zero;
- a rise is backed by the raw input three edges earlier.

The exact commit cycle for a given threshold pair, and the rejection of departures at exactly N and exactly M×1024 cycles, can only be shown by the bench's timed scenarios. The same holds for the counter restart after a brief return to the committed level, on both the fine and the coarse stage.

// File: rtl/hpd_deglitch.sv
module hpd_deglitch #(
  parameter int GLITCH_W   = 4,
  parameter int VALID_W    = 12,
  parameter int SCALE_LOG2 = 10,
  parameter int STAT_W     = 8,
  localparam int CFG_W     = GLITCH_W + VALID_W,
  localparam int RUN_W     = VALID_W + SCALE_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpd_raw,
  input  logic [CFG_W-1:0]  filt_cfg,
  output logic [STAT_W-1:0] hpd_stat,
  output logic              hpd_rise,
  output logic              hpd_fall
);

  logic [1:0]          sync_q;
  logic                lvl_q;
  logic [GLITCH_W-1:0] fine_q;
  logic [RUN_W-1:0]    coarse_q;

  wire                hpd_s   = sync_q[1];
  wire                differ  = hpd_s ^ lvl_q;
  wire [GLITCH_W-1:0] fine_lim = filt_cfg[CFG_W-1:VALID_W];
  wire [VALID_W-1:0]  crs_lim  = filt_cfg[VALID_W-1:0];
  wire                fine_ok  = fine_q >= fine_lim;
  wire                crs_ok   = coarse_q >= {crs_lim, {SCALE_LOG2{1'b0}}};
  wire                commit   = differ & fine_ok & crs_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], hpd_raw};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !differ || commit) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else begin
      if (!(&fine_q))   fine_q   <= fine_q + 1'b1;
      if (!(&coarse_q)) coarse_q <= coarse_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      hpd_rise <= 1'b0;
      hpd_fall <= 1'b0;
    end else begin
      if (commit) lvl_q <= hpd_s;
      hpd_rise <= commit & hpd_s;
      hpd_fall <= commit & ~hpd_s;
    end
  end

  assign hpd_stat = {{(STAT_W-1){1'b0}}, lvl_q};

endmodule

// File: rtl/hpd_deglitch_chk.sv
module hpd_deglitch_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hpd_raw,
  input logic [STAT_W-1:0] hpd_stat,
  input logic              hpd_rise,
  input logic              hpd_fall
);

  p_rise_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_rise |=> !hpd_rise);

  p_rise_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_rise |-> (hpd_stat[0] && !$past(hpd_stat[0])));

  p_fall_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_fall |=> !hpd_fall);

  p_fall_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_fall |-> (!hpd_stat[0] && $past(hpd_stat[0])));

  p_change_has_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hpd_stat[0] != $past(hpd_stat[0])) |-> (hpd_rise || hpd_fall));

  p_no_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hpd_rise && hpd_fall));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_stat[STAT_W-1:1] == '0);

  p_sync_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_rise |-> $past(hpd_raw, 3));

endmodule

bind hpd_deglitch hpd_deglitch_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hpd_raw(hpd_raw),
  .hpd_stat(hpd_stat), .hpd_rise(hpd_rise), .hpd_fall(hpd_fall)
);

// File: tb/hpd_deglitch_bench.sv
`timescale 1ns/1ps
module hpd_deglitch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hpd_raw = 1'b0;
  logic [15:0] filt_cfg = '0;
  logic [7:0]  hpd_stat;
  logic        hpd_rise, hpd_fall;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mlvl = 1'b0;
  int kwin = 0;

  typedef struct { bit is_rise; int at; } ev_t;
  ev_t expq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hpd_deglitch u_hpd_deglitch (
    .clk(clk), .rst_n(rst_n), .hpd_raw(hpd_raw), .filt_cfg(filt_cfg),
    .hpd_stat(hpd_stat), .hpd_rise(hpd_rise), .hpd_fall(hpd_fall)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic set_cfg(input int n, input int m);
    @(negedge clk);
    filt_cfg = {n[3:0], m[11:0]};
    kwin = (n > m * 1024) ? n : m * 1024;
  endtask

  task automatic step(input bit v, input int len);
    ev_t e;
    @(negedge clk);
    hpd_raw = v;
    if (v != mlvl && len > kwin) begin
      e.is_rise = v;
      e.at = cyc + 3 + kwin;
      expq.push_back(e);
      mlvl = v;
    end
    repeat (len - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && (hpd_rise || hpd_fall)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R10 unexpected event", cyc, -1);
      end else begin
        ev_t e;
        e = expq.pop_front();
        if (e.is_rise) begin
          chk(hpd_rise && !hpd_fall && e.at == cyc, "R4/R7 rise timing", cyc, e.at);
          chk(hpd_stat == 8'h01, "R7/R9 level on rise", hpd_stat, 1);
        end else begin
          chk(hpd_fall && !hpd_rise && e.at == cyc, "R4/R8 fall timing", cyc, e.at);
          chk(hpd_stat == 8'h00, "R8/R9 level on fall", hpd_stat, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hpd_stat == 0, "R1 status in reset", hpd_stat, 0);
    chk(!hpd_rise && !hpd_fall, "R1 events in reset", {hpd_rise, hpd_fall}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(hpd_stat == 0, "R1 status after reset", hpd_stat, 0);

    // R2: zero config, single-cycle pulse passes after sync
    set_cfg(0, 0);
    step(1, 1); step(0, 10);
    step(1, 3); step(0, 10);
    chk(hpd_stat == 0, "R9 level back low", hpd_stat, 0);

    // R3 / R4 with N=5
    set_cfg(5, 0);
    step(1, 5); step(0, 20);
    chk(hpd_stat == 0, "R3 glitch of N rejected", hpd_stat, 0);
    step(1, 6); step(0, 20);
    // R6: fine count restarts after a one-cycle return
    step(1, 4); step(0, 1); step(1, 4); step(0, 20);
    chk(hpd_stat == 0, "R6 fine restart", hpd_stat, 0);
    // R3 on a falling dip while high
    step(1, 20); step(0, 5); step(1, 20);
    chk(hpd_stat == 1, "R3 low dip rejected", hpd_stat, 1);
    step(0, 20);

    // N=15 boundary
    set_cfg(15, 0);
    step(1, 15); step(0, 30);
    chk(hpd_stat == 0, "R3 glitch at max N", hpd_stat, 0);
    step(1, 16); step(0, 30);

    // R5 coarse stage with M=1
    set_cfg(0, 1);
    step(1, 1024); step(0, 1100);
    chk(hpd_stat == 0, "R5 width M*1024 rejected", hpd_stat, 0);
    step(1, 1025); step(0, 1100);
    // R6: coarse count restarts
    step(1, 600); step(0, 1); step(1, 600); step(0, 1100);
    chk(hpd_stat == 0, "R6 coarse restart", hpd_stat, 0);

    // both stages, coarse dominates
    set_cfg(3, 1);
    step(1, 1025); step(0, 1100);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R4 all expected events seen", expq.size(), 0);
    chk(hpd_stat == 0, "R9 final status", hpd_stat, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule